// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block turns single-byte host requests into register cycles on an 8-bit bus where address and data share the same lines, toward an external CAN controller. The controller's chip-select pin is also wired to its address-latch input. Every cycle therefore has the same order. First the address goes out with all strobes high. Then chip select falls, and that edge latches the address. Then a data phase runs with a read strobe or a write strobe.

The host raises `req_valid` for one clock while the block is idle. With the request it gives a direction flag, an address and write data. When the cycle ends, the block pulses `done` for one clock, and for a read `rdata` holds the sampled byte in that same clock. The host can also pulse `rst_cmd`. This holds the controller's active-low reset low for a set time, releases it, waits a second set time, and then pulses `done`. The strobe width and both reset delays are parameters.

Top module: `mux_bus_master`

## Requirements
- R1: After `rst_n` is released, `bus_oe` is 0, `done` is 0, and `cs_n`, `rd_n`, `wr_n` and `ctl_rst_n` are all 1.
- R2: In the first clock after a request is accepted, `bus_dout` carries the request address with `bus_oe`=1, while `cs_n`, `rd_n` and `wr_n` are all 1.
- R3: In the next clock `cs_n` falls while the address is still driven. `cs_n` then stays low for one full clock before any strobe falls.
- R4: In a write (`req_write`=1), `bus_dout` carries the write data with `bus_oe`=1 before `wr_n` falls. `wr_n` stays low for exactly `STROBE_CLKS` clocks and rises while `cs_n` is still low. `cs_n` rises one clock later.
- R5: In a read (`req_write`=0), `bus_oe` is 0 before `rd_n` falls. `rd_n` stays low for exactly `STROBE_CLKS` clocks. The returned byte is the value on `bus_din` in the last clock of the low phase. `rd_n` rises before `cs_n`.
- R6: `wr_n` stays 1 throughout a read, and `rd_n` stays 1 throughout a write.
- R7: `done` is high for exactly one clock. For a bus cycle it comes `STROBE_CLKS`+5 clocks after the clock in which the request was sampled, and `rdata` is valid in that clock.
- R8: A `req_valid` seen while a cycle is running is ignored. It produces no bus cycle and no extra `done`.
- R9: `rst_cmd` drives `ctl_rst_n` low for exactly `RST_LOW_CLKS` clocks with `cs_n` held high. `done` follows `RST_WAIT_CLKS` clocks after the release.
- R10: When a reset pulse completes, `bus_oe` is 0 and `cs_n`, `rd_n` and `wr_n` are 1.
- R11: If `rst_cmd` and `req_valid` arrive in the same idle clock, the reset pulse runs and the request is dropped.
- R12: `rd_n` and `wr_n` are never low together, and neither is low while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rst_cmd | input | 1 | Start a controller reset pulse |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read data, valid with `done` after a read |
| bus_dout | output | 8 | Value driven onto the shared lines |
| bus_oe | output | 1 | 1 = block drives the shared lines |
| bus_din | input | 8 | Value seen on the shared lines |
| cs_n | output | 1 | Chip select, also the address latch, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ctl_rst_n | output | 1 | Controller reset, active low |

## Verification
The checker watches every clock for the following:
- strobe exclusivity, and strobes appearing only while chip select is low;
- the exact strobe low width;
- the drive direction during each strobe;
- the address being held stable across the falling edge of chip select;
- chip select staying high during the reset pulse;
- `done` being a single-clock pulse.

Some behaviour can only be shown by the scenarios, because it needs a model of the far-end device:
- whether the latched address and the written byte really land in the right register;
- whether read data is sampled before RD rises;
- completion latency;
- reset delay lengths;
- that requests made while busy, or together with a reset command, leave no trace.

The bench writes and then reads back every address to cover these.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    localparam int unsigned MBM_DW = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LATCH,
        ST_GAP,
        ST_STRB,
        ST_RISE,
        ST_FIN,
        ST_RLO,
        ST_RWT
    } mbm_state_e;

    typedef struct packed {
        mbm_state_e          st;
        logic                is_wr;
        logic [MBM_DW-1:0]   wdata;
        logic [MBM_DW-1:0]   dout;
        logic                oe;
        logic                cs_n;
        logic                rd_n;
        logic                wr_n;
        logic                crst_n;
        logic                done;
        logic [MBM_DW-1:0]   rdata;
    } mbm_regs_t;

endpackage

// File: rtl/mbm_delay.sv
module mbm_delay #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/mbm_ctrl.sv
module mbm_ctrl
    import mbm_pkg::*;
#(
    parameter int unsigned STROBE_CLKS   = 2,
    parameter int unsigned RST_LOW_CLKS  = 6,
    parameter int unsigned RST_WAIT_CLKS = 5,
    parameter int unsigned CNT_W         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [MBM_DW-1:0] req_addr,
    input  logic [MBM_DW-1:0] req_wdata,
    input  logic              rst_cmd,
    input  logic [MBM_DW-1:0] bus_din,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output mbm_regs_t         regs
);
    localparam logic [CNT_W-1:0] STRB_LD = CNT_W'(STROBE_CLKS - 1);
    localparam logic [CNT_W-1:0] RLO_LD  = CNT_W'(RST_LOW_CLKS - 1);
    localparam logic [CNT_W-1:0] RWT_LD  = CNT_W'(RST_WAIT_CLKS - 1);

    mbm_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (rst_cmd) begin
                    r_d.st     = ST_RLO;
                    r_d.crst_n = 1'b0;
                    r_d.oe     = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = RLO_LD;
                end else if (req_valid) begin
                    r_d.st    = ST_ADDR;
                    r_d.is_wr = req_write;
                    r_d.wdata = req_wdata;
                    r_d.dout  = req_addr;
                    r_d.oe    = 1'b1;
                end
            end
            ST_ADDR: begin
                r_d.st   = ST_LATCH;
                r_d.cs_n = 1'b0;
            end
            ST_LATCH: begin
                r_d.st = ST_GAP;
                if (r_q.is_wr) begin
                    r_d.dout = r_q.wdata;
                    r_d.oe   = 1'b1;
                end else begin
                    r_d.oe   = 1'b0;
                end
            end
            ST_GAP: begin
                r_d.st   = ST_STRB;
                tmr_load = 1'b1;
                tmr_val  = STRB_LD;
                if (r_q.is_wr) r_d.wr_n = 1'b0;
                else           r_d.rd_n = 1'b0;
            end
            ST_STRB: begin
                if (tmr_zero) begin
                    r_d.st   = ST_RISE;
                    r_d.wr_n = 1'b1;
                    r_d.rd_n = 1'b1;
                    if (!r_q.is_wr) r_d.rdata = bus_din;
                end
            end
            ST_RISE: begin
                r_d.st   = ST_FIN;
                r_d.cs_n = 1'b1;
                r_d.oe   = 1'b0;
                r_d.done = 1'b1;
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            ST_RLO: begin
                if (tmr_zero) begin
                    r_d.st     = ST_RWT;
                    r_d.crst_n = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = RWT_LD;
                end
            end
            ST_RWT: begin
                if (tmr_zero) begin
                    r_d.st   = ST_FIN;
                    r_d.done = 1'b1;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.is_wr  <= 1'b0;
            r_q.wdata  <= '0;
            r_q.dout   <= '0;
            r_q.oe     <= 1'b0;
            r_q.cs_n   <= 1'b1;
            r_q.rd_n   <= 1'b1;
            r_q.wr_n   <= 1'b1;
            r_q.crst_n <= 1'b1;
            r_q.done   <= 1'b0;
            r_q.rdata  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs = r_q;
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
    import mbm_pkg::*;
#(
    parameter int unsigned STROBE_CLKS   = 2,
    parameter int unsigned RST_LOW_CLKS  = 6,
    parameter int unsigned RST_WAIT_CLKS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [MBM_DW-1:0] req_addr,
    input  logic [MBM_DW-1:0] req_wdata,
    input  logic              rst_cmd,
    output logic              done,
    output logic [MBM_DW-1:0] rdata,
    output logic [MBM_DW-1:0] bus_dout,
    output logic              bus_oe,
    input  logic [MBM_DW-1:0] bus_din,
    output logic              cs_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ctl_rst_n
);
    localparam int unsigned MAX_A = (STROBE_CLKS > RST_LOW_CLKS) ? STROBE_CLKS : RST_LOW_CLKS;
    localparam int unsigned MAX_C = (MAX_A > RST_WAIT_CLKS) ? MAX_A : RST_WAIT_CLKS;
    localparam int unsigned CNT_W = $clog2(MAX_C) + 1;

    generate
        if (STROBE_CLKS < 2) begin : g_bad_strobe
            $error("STROBE_CLKS must be at least 2");
        end
        if (RST_LOW_CLKS < 1 || RST_WAIT_CLKS < 1) begin : g_bad_rst
            $error("reset delays must be at least 1");
        end
    endgenerate

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    mbm_regs_t        regs;

    mbm_delay #(.CNT_W(CNT_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    mbm_ctrl #(
        .STROBE_CLKS   (STROBE_CLKS),
        .RST_LOW_CLKS  (RST_LOW_CLKS),
        .RST_WAIT_CLKS (RST_WAIT_CLKS),
        .CNT_W         (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rst_cmd   (rst_cmd),
        .bus_din   (bus_din),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .regs      (regs)
    );

    assign done      = regs.done;
    assign rdata     = regs.rdata;
    assign bus_dout  = regs.dout;
    assign bus_oe    = regs.oe;
    assign cs_n      = regs.cs_n;
    assign rd_n      = regs.rd_n;
    assign wr_n      = regs.wr_n;
    assign ctl_rst_n = regs.crst_n;
endmodule

// File: rtl/mbm_checker.sv
module mbm_checker #(
    parameter int unsigned STROBE_CLKS = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic [7:0] bus_dout,
    input logic       bus_oe,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       ctl_rst_n
);
    logic [15:0] wr_lo_q, rd_lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_lo_q <= '0;
            rd_lo_q <= '0;
        end else begin
            wr_lo_q <= wr_n ? 16'd0 : wr_lo_q + 16'd1;
            rd_lo_q <= rd_n ? 16'd0 : rd_lo_q + 16'd1;
        end
    end

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    assert_strobe_in_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !cs_n);
    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (bus_oe && $stable(bus_dout)));
    assert_wr_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> bus_oe);
    assert_wr_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (wr_lo_q == 16'(STROBE_CLKS) && !cs_n));
    assert_rd_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_oe);
    assert_rd_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> (rd_lo_q == 16'(STROBE_CLKS) && !cs_n));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_rst_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rst_n |-> (cs_n && rd_n && wr_n));
endmodule

bind mux_bus_master mbm_checker #(.STROBE_CLKS(STROBE_CLKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .bus_dout  (bus_dout),
    .bus_oe    (bus_oe),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ctl_rst_n (ctl_rst_n)
);

// File: tb/mux_bus_master_tb.sv
module mux_bus_master_tb;
    localparam int S = 3;
    localparam int L = 4;
    localparam int W = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, rst_cmd = 1'b0;
    logic [7:0] req_addr = '0, req_wdata = '0;
    logic       done, bus_oe, cs_n, rd_n, wr_n, ctl_rst_n;
    logic [7:0] rdata, bus_dout, bus_din;

    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    mux_bus_master #(.STROBE_CLKS(S), .RST_LOW_CLKS(L), .RST_WAIT_CLKS(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rst_cmd(rst_cmd),
        .done(done), .rdata(rdata), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .bus_din(bus_din), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .ctl_rst_n(ctl_rst_n)
    );

    // far-end device model
    logic [7:0] dev_mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] dev_lat = '0;
    always @(negedge cs_n) dev_lat = bus_dout;
    always @(posedge wr_n) if (cs_n === 1'b0) dev_mem[dev_lat] = bus_dout;
    assign bus_din = (cs_n === 1'b0 && rd_n === 1'b0) ? dev_mem[dev_lat] : 8'hA5;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_op(input bit w, input logic [7:0] a, input logic [7:0] d,
                          input bit inject, output logic [7:0] got);
        int i, wlo, rlo;
        bit seen;
        i = 0; wlo = 0; rlo = 0; seen = 0; got = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        while (!seen && i < 40) begin
            @(negedge clk);
            i++;
            if (i == 1) begin
                req_valid = 1'b0;
                chk(bus_oe && bus_dout == a && cs_n && rd_n && wr_n, "R2", bus_dout, a);
            end
            if (i == 2) chk(!cs_n && bus_oe && bus_dout == a, "R3", {cs_n, bus_dout}, {1'b0, a});
            if (i == 3) begin
                chk(!cs_n && rd_n && wr_n, "R3 gap", {cs_n, rd_n, wr_n}, 3'b011);
                if (w) chk(bus_oe && bus_dout == d, "R4 data", bus_dout, d);
                else   chk(!bus_oe, "R5 release", bus_oe, 0);
                if (inject) begin
                    req_valid = 1'b1; req_write = 1'b1;
                    req_addr = a ^ 8'h80; req_wdata = ~d;
                end
            end
            if (i == 4) req_valid = 1'b0;
            if (!wr_n) wlo++;
            if (!rd_n) rlo++;
            if (i == S + 4) chk(cs_n == 1'b0 && rd_n && wr_n, "R4/R5 strobe before cs", cs_n, 0);
            if (done) begin seen = 1; got = rdata; end
        end
        chk(i == S + 5, "R7 latency", i, S + 5);
        @(negedge clk);
        chk(!done, "R7 pulse", done, 0);
        if (w) begin
            chk(wlo == S, "R4 width", wlo, S);
            chk(rlo == 0, "R6 rd in write", rlo, 0);
        end else begin
            chk(rlo == S, "R5 width", rlo, S);
            chk(wlo == 0, "R6 wr in read", wlo, 0);
        end
        if (inject) begin
            repeat (12) begin
                @(negedge clk);
                chk(!done && cs_n, "R8 no second cycle", {done, cs_n}, 2'b01);
            end
        end
    endtask

    task automatic rst_op(input bit with_req);
        int i, lo, cslo;
        bit seen;
        i = 0; lo = 0; cslo = 0; seen = 0;
        @(negedge clk);
        rst_cmd = 1'b1;
        if (with_req) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h33; req_wdata = 8'hEE;
        end
        while (!seen && i < 40) begin
            @(negedge clk);
            i++;
            if (i == 1) begin rst_cmd = 1'b0; req_valid = 1'b0; end
            if (!ctl_rst_n) lo++;
            if (!cs_n) cslo++;
            if (done) seen = 1;
        end
        chk(lo == L, "R9 low width", lo, L);
        chk(i == L + W + 1, "R9 done delay", i, L + W + 1);
        chk(cslo == 0, with_req ? "R11 no bus cycle" : "R9 cs high", cslo, 0);
        chk(!bus_oe && cs_n && rd_n && wr_n && ctl_rst_n, "R10 idle levels",
            {bus_oe, cs_n, rd_n, wr_n, ctl_rst_n}, 5'b01111);
        @(negedge clk);
        chk(!done, "R7 pulse after reset", done, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] got;
        for (int k = 0; k < 256; k++) begin
            dev_mem[k] = 8'(k) ^ 8'h5A;
            exp_mem[k] = 8'(k) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_oe && !done && cs_n && rd_n && wr_n && ctl_rst_n, "R1 reset state",
            {bus_oe, done, cs_n, rd_n, wr_n, ctl_rst_n}, 6'b001111);

        rst_op(1'b0);

        // sweep: read initial contents of a slice, write every address, read all back
        for (int a = 0; a < 16; a++) begin
            bus_op(1'b0, 8'(a * 17), 8'h00, 1'b0, got);
            chk(got == exp_mem[8'(a * 17)], "R5 read initial", got, exp_mem[8'(a * 17)]);
        end
        for (int a = 0; a < 256; a++) begin
            bus_op(1'b1, 8'(a), 8'((a * 37 + 11) & 255), 1'b0, got);
            exp_mem[a] = 8'((a * 37 + 11) & 255);
        end
        for (int a = 0; a < 256; a++) begin
            bus_op(1'b0, 8'(a), 8'h00, 1'b0, got);
            chk(got == exp_mem[a], "R4/R5 readback", got, exp_mem[a]);
        end

        // R8: request injected mid-cycle must leave no trace
        bus_op(1'b1, 8'h10, 8'h3C, 1'b1, got);
        exp_mem[8'h10] = 8'h3C;
        bus_op(1'b0, 8'h90, 8'h00, 1'b0, got);
        chk(got == exp_mem[8'h90], "R8 ignored write", got, exp_mem[8'h90]);
        bus_op(1'b0, 8'h10, 8'h00, 1'b1, got);
        chk(got == exp_mem[8'h10], "R8 read during inject", got, exp_mem[8'h10]);

        // R11: reset wins over simultaneous request
        rst_op(1'b1);
        bus_op(1'b0, 8'h33, 8'h00, 1'b0, got);
        chk(got == exp_mem[8'h33], "R11 dropped write", got, exp_mem[8'h33]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule